// File: doc/BRIEF.md
# Windowed Watchdog Timer with Service Keys

This block is a register-mapped watchdog for a system that has to prove, at regular intervals, that its software is still running correctly. Software loads a 12-bit reload value, picks how wide the service window is, and picks the reaction to a fault. It then arms the timer by writing a 32-bit arming key. From that point a down-counter runs one step per clock from the reload value times 2^PRE_SHIFT. Software cannot stop it again. Only a reset stops it.

Software services the timer with a two-word key sequence written to one key register. The service counts only when the counter has already fallen into the open window at the end of the period. A service that comes too early is a fault. So is a counter that reaches zero. Either fault sets a sticky status flag, reloads the counter and emits a one-cycle pulse. The pulse goes out on the reset output or the NMI output, depending on the reaction register. Software reads the running count through the bus.

Top module: `win_wdog`

## Requirements
- R1: After reset, control reads 0, counter reads 0, status reads 0, reload reads 0xFFF, window reads 0x50, reaction reads 0x5, and both pulse outputs are low.
- R2: Writing exactly 0xA98559DA to offset 0x90 starts the timer. The counter (offset 0xA0) reads reload<<PRE_SHIFT on the next cycle and control then reads 0xA98559DA. Any other value written to 0x90 leaves the timer stopped.
- R3: While the timer runs, the counter falls by one every clock. While the timer is stopped, the counter holds at zero.
- R4: Once started, the timer ignores every further write to offset 0x90 and keeps running until reset.
- R5: A service is the word 0xE51A followed by the word 0xA35C, both written to offset 0x9C. It reloads the counter to reload<<PRE_SHIFT on the cycle of the second write.
- R6: A key write that is not the expected next word returns the sequence to idle without servicing. A lone 0xA35C has no effect.
- R7: The window register (offset 0xA8) sets the open window as a final fraction of the period: 0x50 gives 1/2, 0x500 gives 1/4, 0x5000 gives 1/8, 0x50000 gives 1/16 and 0x500000 gives 1/32. The window is open while counter <= (reload<<PRE_SHIFT) scaled by that fraction. Any other code opens the whole period.
- R8: A completed service while the counter is above the window threshold is a violation. It sets status bit 1 (offset 0x98), reloads the counter and emits one pulse.
- R9: When the counter reads zero while running, the next clock sets status bit 1, reloads the counter and emits one pulse.
- R10: If the reaction register (offset 0xA4) holds 0xA, a violation pulses `nmi_pulse`; any other value pulses `rst_pulse`. Each pulse lasts one cycle, and the two outputs never pulse together.
- R11: Writing a 1 to status bit 1 clears the flag, and writing 0 leaves it set. A violation in the same cycle as the clear wins.
- R12: The reload register at offset 0x94 keeps only the low 12 bits written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rst_pulse | output | 1 | One-cycle reset request on a violation |
| nmi_pulse | output | 1 | One-cycle NMI request on a violation |

## Verification
The bound checker watches these every cycle:
- the counter steps down by one while nothing reloads it, and holds at zero while stopped;
- the running state is sticky;
- a wrong key word leaves the sequence idle;
- a zero count raises the flag;
- every pulse comes with the flag set, and the two pulse outputs never overlap.

Only the directed scenarios can show the rest:
- window placement for the different size codes;
- the early-versus-late outcome of a full key sequence;
- the exact reload values seen on readback;
- which output a chosen reaction drives;
- the clear rule for the status flag.

// File: rtl/win_wdog_pkg.sv
// Package: shared constants, key state type and window decode for the
// windowed watchdog. Assumes an 8-bit byte-offset register bus.
package win_wdog_pkg;

    localparam int          ADDR_W    = 8;
    localparam int          DATA_W    = 32;

    localparam logic [7:0]  OFS_CTRL  = 8'h90;
    localparam logic [7:0]  OFS_PRE   = 8'h94;
    localparam logic [7:0]  OFS_STAT  = 8'h98;
    localparam logic [7:0]  OFS_KEY   = 8'h9C;
    localparam logic [7:0]  OFS_CNT   = 8'hA0;
    localparam logic [7:0]  OFS_REACT = 8'hA4;
    localparam logic [7:0]  OFS_WIN   = 8'hA8;

    localparam logic [31:0] ARM_KEY   = 32'hA98559DA;
    localparam logic [31:0] SVC_OPEN  = 32'h0000E51A;
    localparam logic [31:0] SVC_CLOSE = 32'h0000A35C;
    localparam logic [31:0] REACT_NMI = 32'h0000000A;
    localparam logic [31:0] REACT_RST = 32'h00000005;
    localparam logic [31:0] WIN_RESET = 32'h00000050;

    typedef enum logic {
        KS_IDLE = 1'b0,
        KS_OPEN = 1'b1
    } key_state_e;

    // Right-shift that turns the full period into the window threshold.
    // Unknown codes give 0, so the whole period is open.
    function automatic logic [2:0] win_shift(input logic [31:0] code);
        case (code)
            32'h00000050: win_shift = 3'd1;
            32'h00000500: win_shift = 3'd2;
            32'h00005000: win_shift = 3'd3;
            32'h00050000: win_shift = 3'd4;
            32'h00500000: win_shift = 3'd5;
            default:      win_shift = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/wdg_keyseq.sv
// Module: two-word service key tracker.
// Watches key-register writes and raises `service` for the cycle in which
// the second word of a correct sequence is written. Assumes `key_wr` is a
// one-cycle strobe. The tracker stays idle while the timer is stopped.
module wdg_keyseq
    import win_wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        running,
    input  logic        key_wr,
    input  logic [31:0] wdata,
    output logic        service,
    output logic        armed
);

    key_state_e st_q;

    // Purpose: a completed sequence is the closing word while already opened.
    always_comb begin
        service = running && key_wr && (st_q == KS_OPEN) && (wdata == SVC_CLOSE);
    end

    assign armed = (st_q == KS_OPEN);

    // Purpose: advance on the opening word, fall back to idle on any other write.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) begin
            st_q <= KS_IDLE;
        end else if (key_wr) begin
            if (st_q == KS_IDLE && wdata == SVC_OPEN) begin
                st_q <= KS_OPEN;
            end else begin
                st_q <= KS_IDLE;
            end
        end
    end

endmodule

// File: rtl/wdg_downcount.sv
// Module: period down-counter with end-of-period window check.
// Loads reload<<PRE_SHIFT on start, on service and on any violation, and
// decrements once per clock while running. Flags a violation on a zero
// count or on a service above the window threshold. Assumes the reload
// value and window code come from registers held stable by the caller.
module wdg_downcount
    import win_wdog_pkg::*;
#(
    parameter int PRE_W     = 12,
    parameter int PRE_SHIFT = 13,
    parameter int CNT_W     = PRE_W + PRE_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             start,
    input  logic             service,
    input  logic [PRE_W-1:0] preload,
    input  logic [31:0]      win_code,
    output logic [CNT_W-1:0] cnt,
    output logic             viol
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] full;
    logic [CNT_W-1:0] thr;
    logic             early;
    logic             expire;

    // Purpose: derive the full period and the window threshold.
    always_comb begin
        full = {preload, {PRE_SHIFT{1'b0}}};
        thr  = full >> win_shift(win_code);
    end

    // Purpose: classify faults from the current count.
    always_comb begin
        early  = service && (cnt_q > thr);
        expire = running && (cnt_q == '0);
        viol   = early || expire;
    end

    // Purpose: reload or step the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start || viol || service) begin
            cnt_q <= full;
        end else if (running) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/wdg_regfile.sv
// Module: register file and bus decode for the windowed watchdog.
// Holds run state, reload value, window code, reaction choice and the
// sticky fault flag, and generates the one-cycle reaction pulses. Reads
// are combinational. Assumes CNT_W <= 32.
module wdg_regfile
    import win_wdog_pkg::*;
#(
    parameter int PRE_W = 12,
    parameter int CNT_W = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              viol,
    output logic              running,
    output logic              start,
    output logic              key_wr,
    output logic [PRE_W-1:0]  preload,
    output logic [31:0]       win_code,
    output logic              flag,
    output logic              rst_pulse,
    output logic              nmi_pulse
);

    localparam int PAD_W = DATA_W - CNT_W;

    logic              run_q;
    logic [PRE_W-1:0]  pre_q;
    logic [31:0]       win_q;
    logic [31:0]       react_q;
    logic              flag_q;
    logic [1:0]        pulse_q;
    logic              wr_ctrl, wr_pre, wr_stat, wr_react, wr_win;
    logic [1:0]        pulse_d;

    // Purpose: decode write strobes per register.
    always_comb begin
        wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
        wr_pre   = bus_wr && (bus_addr == OFS_PRE);
        wr_stat  = bus_wr && (bus_addr == OFS_STAT);
        key_wr   = bus_wr && (bus_addr == OFS_KEY);
        wr_react = bus_wr && (bus_addr == OFS_REACT);
        wr_win   = bus_wr && (bus_addr == OFS_WIN);
        start    = wr_ctrl && !run_q && (bus_wdata == ARM_KEY);
    end

    // Purpose: route a violation to one of the two reaction outputs.
    always_comb begin
        pulse_d[0] = viol && (react_q != REACT_NMI);
        pulse_d[1] = viol && (react_q == REACT_NMI);
    end

    // Purpose: configuration registers and the sticky run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            pre_q   <= '1;
            win_q   <= WIN_RESET;
            react_q <= REACT_RST;
        end else begin
            if (start)    run_q   <= 1'b1;
            if (wr_pre)   pre_q   <= bus_wdata[PRE_W-1:0];
            if (wr_win)   win_q   <= bus_wdata;
            if (wr_react) react_q <= bus_wdata;
        end
    end

    // Purpose: fault flag, set by a violation, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (viol) begin
            flag_q <= 1'b1;
        end else if (wr_stat && bus_wdata[1]) begin
            flag_q <= 1'b0;
        end
    end

    // Purpose: register each reaction output as a one-cycle pulse.
    for (genvar g = 0; g < 2; g++) begin : g_pulse
        always_ff @(posedge clk) begin
            if (!rst_n) pulse_q[g] <= 1'b0;
            else        pulse_q[g] <= pulse_d[g];
        end
    end

    // Purpose: combinational read mux.
    always_comb begin
        case (bus_addr)
            OFS_CTRL:  bus_rdata = run_q ? ARM_KEY : '0;
            OFS_PRE:   bus_rdata = {{(DATA_W-PRE_W){1'b0}}, pre_q};
            OFS_STAT:  bus_rdata = {{(DATA_W-2){1'b0}}, flag_q, 1'b0};
            OFS_CNT:   bus_rdata = {{PAD_W{1'b0}}, cnt};
            OFS_REACT: bus_rdata = react_q;
            OFS_WIN:   bus_rdata = win_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign running   = run_q;
    assign preload   = pre_q;
    assign win_code  = win_q;
    assign flag      = flag_q;
    assign rst_pulse = pulse_q[0];
    assign nmi_pulse = pulse_q[1];

endmodule

// File: rtl/win_wdog.sv
// Module: windowed watchdog top level.
// Ties the register file, the key tracker and the down-counter together.
// PRE_SHIFT scales the 12-bit reload value into the period count.
module win_wdog
    import win_wdog_pkg::*;
#(
    parameter int PRE_W     = 12,
    parameter int PRE_SHIFT = 13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        rst_pulse,
    output logic        nmi_pulse
);

    localparam int CNT_W = PRE_W + PRE_SHIFT;

    logic             running, start, key_wr, service, armed, viol, flag;
    logic [PRE_W-1:0] preload;
    logic [31:0]      win_code;
    logic [CNT_W-1:0] cnt;

    wdg_regfile #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt(cnt), .viol(viol),
        .running(running), .start(start), .key_wr(key_wr), .preload(preload),
        .win_code(win_code), .flag(flag), .rst_pulse(rst_pulse),
        .nmi_pulse(nmi_pulse)
    );

    wdg_keyseq u_keys (
        .clk(clk), .rst_n(rst_n), .running(running), .key_wr(key_wr),
        .wdata(bus_wdata), .service(service), .armed(armed)
    );

    wdg_downcount #(.PRE_W(PRE_W), .PRE_SHIFT(PRE_SHIFT), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .running(running), .start(start),
        .service(service), .preload(preload), .win_code(win_code),
        .cnt(cnt), .viol(viol)
    );

endmodule

// File: rtl/win_wdog_chk.sv
// Module: assertion checker for the windowed watchdog, bound to win_wdog.
module win_wdog_chk
    import win_wdog_pkg::*;
#(
    parameter int CNT_W = 25
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic             start,
    input logic             service,
    input logic             armed,
    input logic             flag,
    input logic [CNT_W-1:0] cnt,
    input logic             bus_wr,
    input logic [7:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             rst_pulse,
    input logic             nmi_pulse
);

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (cnt == '0));

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !start && !service && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    p_sticky_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);

    p_bad_key_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_KEY && bus_wdata != SVC_OPEN) |=> !armed);

    p_pulse_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_pulse || nmi_pulse) |-> flag);

    p_expire_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt == '0) |=> flag);

    p_excl_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_pulse && nmi_pulse));

endmodule

bind win_wdog win_wdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .running(running), .start(start),
    .service(service), .armed(armed), .flag(flag), .cnt(cnt),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rst_pulse(rst_pulse), .nmi_pulse(nmi_pulse)
);

// File: tb/win_wdog_tb_top.sv
// Directed bench for the windowed watchdog, PRE_SHIFT reduced to 4.
module win_wdog_tb_top;

    localparam int SHIFT = 4;
    localparam logic [7:0] A_CTRL = 8'h90, A_PRE = 8'h94, A_STAT = 8'h98,
                           A_KEY = 8'h9C, A_CNT = 8'hA0, A_REACT = 8'hA4,
                           A_WIN = 8'hA8;
    localparam logic [31:0] K_ARM = 32'hA98559DA, K_OPEN = 32'hE51A,
                            K_CLOSE = 32'hA35C;
    localparam logic [31:0] FULL = 32'h10 << SHIFT; // 256

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_pulse, nmi_pulse;

    int total = 0;
    int bad = 0;
    int n_rst = 0;
    int n_nmi = 0;

    always #4 clk = ~clk;

    win_wdog #(.PRE_W(12), .PRE_SHIFT(SHIFT)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_pulse(rst_pulse), .nmi_pulse(nmi_pulse)
    );

    // Count high cycles of each reaction output.
    always @(negedge clk) begin
        if (rst_pulse) n_rst++;
        if (nmi_pulse) n_nmi++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_below(input logic [31:0] lim);
        logic [31:0] v;
        do begin
            @(negedge clk);
            rd(A_CNT, v);
        end while (v > lim);
    endtask

    task automatic service_keys();
        wr(A_KEY, K_OPEN);
        wr(A_KEY, K_CLOSE);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTRL, v);  chk(v == 0, "R1 ctrl", v, 0);
        rd(A_CNT, v);   chk(v == 0, "R1 cnt", v, 0);
        rd(A_STAT, v);  chk(v == 0, "R1 stat", v, 0);
        rd(A_PRE, v);   chk(v == 32'hFFF, "R1 pre", v, 32'hFFF);
        rd(A_WIN, v);   chk(v == 32'h50, "R1 win", v, 32'h50);
        rd(A_REACT, v); chk(v == 32'h5, "R1 react", v, 32'h5);
        chk(n_rst == 0 && n_nmi == 0, "R1 pulses", n_rst + n_nmi, 0);
    endtask

    task automatic t_preload_width();
        logic [31:0] v;
        wr(A_PRE, 32'h0001_2345);
        rd(A_PRE, v); chk(v == 32'h345, "R12 pre mask", v, 32'h345);
        wr(A_PRE, 32'h10);
    endtask

    task automatic t_bad_enable();
        logic [31:0] v;
        wr(A_CTRL, 32'hA98559DB);
        cycles(3);
        rd(A_CTRL, v); chk(v == 0, "R2 wrong key ctrl", v, 0);
        rd(A_CNT, v);  chk(v == 0, "R3 stopped cnt", v, 0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(A_CTRL, K_ARM);
        rd(A_CNT, v);  chk(v == FULL, "R2 load", v, FULL);
        rd(A_CTRL, v); chk(v == K_ARM, "R2 ctrl readback", v, K_ARM);
        cycles(10);
        rd(A_CNT, v);  chk(v == FULL - 10, "R3 step", v, FULL - 10);
    endtask

    task automatic t_early();
        logic [31:0] v;
        int r0 = n_rst;
        service_keys();
        rd(A_CNT, v);  chk(v == FULL, "R8 reload", v, FULL);
        cycles(1);
        chk(n_rst == r0 + 1, "R8/R10 rst pulse", n_rst, r0 + 1);
        chk(n_nmi == 0, "R10 no nmi", n_nmi, 0);
        rd(A_STAT, v); chk(v == 2, "R8 flag", v, 2);
    endtask

    task automatic t_status_clear();
        logic [31:0] v;
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk(v == 2, "R11 write zero", v, 2);
        wr(A_STAT, 32'h2);
        rd(A_STAT, v); chk(v == 0, "R11 clear", v, 0);
    endtask

    task automatic t_good_service();
        logic [31:0] v;
        int r0 = n_rst;
        wait_below(120);
        service_keys();
        rd(A_CNT, v);  chk(v == FULL, "R5 reload", v, FULL);
        cycles(1);
        chk(n_rst == r0, "R5 no pulse", n_rst, r0);
        rd(A_STAT, v); chk(v == 0, "R5 no flag", v, 0);
    endtask

    task automatic t_bad_sequence();
        logic [31:0] v0, v;
        int r0 = n_rst;
        wait_below(120);
        rd(A_CNT, v0);
        wr(A_KEY, K_OPEN);
        wr(A_KEY, 32'h1234);
        wr(A_KEY, K_CLOSE);
        rd(A_CNT, v);  chk(v == v0 - 6, "R6 no service", v, v0 - 6);
        chk(n_rst == r0, "R6 no pulse", n_rst, r0);
        service_keys();
        rd(A_CNT, v);  chk(v == FULL, "R6 recover", v, FULL);
    endtask

    task automatic t_window25();
        logic [31:0] v;
        int r0 = n_rst;
        wr(A_WIN, 32'h500);
        wait_below(100);
        service_keys();
        cycles(1);
        chk(n_rst == r0 + 1, "R7 quarter early", n_rst, r0 + 1);
        wr(A_STAT, 32'h2);
        wait_below(56);
        service_keys();
        cycles(1);
        chk(n_rst == r0 + 1, "R7 quarter inside", n_rst, r0 + 1);
        rd(A_STAT, v); chk(v == 0, "R7 quarter flag", v, 0);
    endtask

    task automatic t_window_open();
        logic [31:0] v;
        int r0 = n_rst;
        wr(A_WIN, 32'h7);
        cycles(4);
        service_keys();
        rd(A_CNT, v);  chk(v == FULL, "R7 unlisted reload", v, FULL);
        cycles(1);
        chk(n_rst == r0, "R7 unlisted no pulse", n_rst, r0);
        wr(A_WIN, 32'h50);
    endtask

    task automatic t_no_disable();
        logic [31:0] v1, v2;
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, v1); chk(v1 == K_ARM, "R4 ctrl kept", v1, K_ARM);
        rd(A_CNT, v1);
        cycles(5);
        rd(A_CNT, v2); chk(v2 == v1 - 5, "R4 still counting", v2, v1 - 5);
    endtask

    task automatic t_expire_nmi();
        logic [31:0] v;
        int r0 = n_rst;
        int m0 = n_nmi;
        wr(A_REACT, 32'hA);
        rd(A_REACT, v); chk(v == 32'hA, "R10 react readback", v, 32'hA);
        cycles(300);
        chk(n_nmi == m0 + 1, "R9/R10 nmi once", n_nmi, m0 + 1);
        chk(n_rst == r0, "R10 no rst", n_rst, r0);
        rd(A_STAT, v); chk(v == 2, "R9 flag", v, 2);
        rd(A_CNT, v);  chk(v != 0 && v < FULL, "R9 reloaded", v, FULL);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        t_reset();
        t_preload_width();
        t_bad_enable();
        t_enable();
        t_early();
        t_status_clear();
        t_good_service();
        t_bad_sequence();
        t_window25();
        t_window_open();
        t_no_disable();
        t_expire_nmi();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule